// File: doc/BRIEF.md
# Temperature Monitor Command and Register Core

This block is the register and command core of a temperature monitor that is reached over a two-wire management bus. A byte-level front end, already decoded, hands it one request per cycle: an 8-bit command code, a read/write flag and, for writes, one data byte. The core turns the code into a register read, a register write or a one-shot conversion trigger. It holds the configuration, conversion-rate, high-limit and low-limit bytes. It answers a read one cycle later with the temperature byte, a status byte or a register byte.

Reading and writing the same register use different codes. A write code presented as a read, or a read code presented as a write, is treated like a reserved code.

The core drives an external conversion engine through a single-cycle start pulse and takes back a done pulse together with the 8-bit two's-complement result. The result is stored and compared against the limits, and sticky out-of-range flags are set from that comparison. In auto-convert mode the core starts conversions on its own, on a period set by the conversion-rate byte. In stand-by mode it converts only when a one-shot command arrives, and then only if no conversion is running.

Top module: `thermal_cmd_core`

## Requirements
- R1: After reset the temperature byte is 00h, configuration is 00h, conversion rate is 02h, high limit is 7Fh, low limit is C9h, both flags are clear, and conv_start and rsp_valid are low.
- R2: A read request (req_read=1) with code 01h, 02h, 03h, 04h, 07h or 08h returns, in the same order, temperature, status, configuration, conversion rate, high limit or low limit. rsp_valid is high with rsp_data on the cycle after the request cycle.
- R3: A write request (req_read=0) with code 09h, 0Ah, 0Dh or 0Eh loads req_data into, in the same order, configuration, conversion rate, high limit or low limit.
- R4: Reserved codes (00h, 05h, 06h, 0Bh, 0Ch, 10h–FFh), write codes used as reads and read codes used as writes change no register, and a read of any of them returns 00h.
- R5: The status byte has busy in bit 7, the high flag in bit 4, the low flag in bit 3, and zero elsewhere. Busy rises with conv_start and stays high until the cycle after the first conv_done.
- R6: A conv_done while busy stores conv_result into the temperature byte. A conv_done while not busy is ignored.
- R7: On a stored result, the high flag sets if the result is greater than the high limit, and the low flag sets if it is less than the low limit, both compared as signed bytes. The flags are sticky. A status read returns them and then clears them, but a flag set in the same cycle as the read survives.
- R8: Configuration bit 6 set selects stand-by. In stand-by an idle core given code 0Fh as a write pulses conv_start on the next cycle and starts no further conversion by itself.
- R9: Code 0Fh received while a conversion is in progress starts nothing.
- R10: Code 0Fh received in auto-convert mode starts nothing.
- R11: In auto-convert mode, an idle core pulses conv_start for one cycle, rate+1 cycles after the later of reset release, the last done, or entry into auto-convert mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_read | input | 1 | 1 for read, 0 for write or send-byte |
| req_code | input | 8 | Command code |
| req_data | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 8 | Read response byte |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 8 | Signed conversion result |

## Verification
The bench pins down when the first automatic start happens after reset and after a done. A timer that is off by one moves the start pulse by a cycle. The bench sends a one-shot while busy and another in auto-convert mode; a core that ignored mode or busy would emit an extra start pulse. It applies a status read in the same cycle as a done, so a core that gives the clear priority would lose the new flag. It also uses a result below a negative low limit, and an unsigned compare would miss that flag. Reserved codes, and codes sent with the wrong direction, are written and read back: a loose decoder would change a register or return data other than 00h.

// File: rtl/thermal_cmd_core.sv
module thermal_cmd_core #(
  parameter logic [7:0] RATE_INIT = 8'h02,
  parameter logic [7:0] HI_INIT   = 8'h7F,
  parameter logic [7:0] LO_INIT   = 8'hC9,
  parameter int         STBY_BIT  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_read,
  input  logic [7:0] req_code,
  input  logic [7:0] req_data,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       conv_start,
  input  logic       conv_done,
  input  logic [7:0] conv_result
);

  localparam logic [7:0] RD_TEMP = 8'h01, RD_STAT = 8'h02, RD_CFG = 8'h03, RD_RATE = 8'h04;
  localparam logic [7:0] RD_HI   = 8'h07, RD_LO   = 8'h08;
  localparam logic [7:0] WR_CFG  = 8'h09, WR_RATE = 8'h0A, WR_HI  = 8'h0D, WR_LO   = 8'h0E;
  localparam logic [7:0] ONESHOT = 8'h0F;

  logic [7:0] temp_q, cfg_q, rate_q, hi_q, lo_q, tmr_q, rd_mux;
  logic       busy_q, flag_hi_q, flag_lo_q;

  wire standby   = cfg_q[STBY_BIT];
  wire wr        = req_valid & ~req_read;
  wire rd        = req_valid &  req_read;
  wire os_fire   = wr && (req_code == ONESHOT) && standby && !busy_q;
  wire auto_fire = !standby && !busy_q && (tmr_q >= rate_q);
  wire fire      = os_fire | auto_fire;
  wire finish    = busy_q & conv_done;
  wire above     = $signed(conv_result) > $signed(hi_q);
  wire below     = $signed(conv_result) < $signed(lo_q);
  wire stat_rd   = rd && (req_code == RD_STAT);
  wire [7:0] status = {busy_q, 2'b00, flag_hi_q, flag_lo_q, 3'b000};
  wire wr_known  = (req_code == WR_CFG) || (req_code == WR_RATE) ||
                   (req_code == WR_HI)  || (req_code == WR_LO)   || (req_code == ONESHOT);

  always_comb begin
    case (req_code)
      RD_TEMP: rd_mux = temp_q;
      RD_STAT: rd_mux = status;
      RD_CFG:  rd_mux = cfg_q;
      RD_RATE: rd_mux = rate_q;
      RD_HI:   rd_mux = hi_q;
      RD_LO:   rd_mux = lo_q;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 8'h00;
      rate_q <= RATE_INIT;
      hi_q   <= HI_INIT;
      lo_q   <= LO_INIT;
    end else if (wr) begin
      case (req_code)
        WR_CFG:  cfg_q  <= req_data;
        WR_RATE: rate_q <= req_data;
        WR_HI:   hi_q   <= req_data;
        WR_LO:   lo_q   <= req_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      conv_start <= 1'b0;
      tmr_q      <= 8'h00;
      temp_q     <= 8'h00;
    end else begin
      conv_start <= fire;
      if (fire)        busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      if (finish) temp_q <= conv_result;
      if (busy_q || standby || fire) tmr_q <= 8'h00;
      else if (tmr_q != 8'hFF)       tmr_q <= tmr_q + 8'h01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hi_q <= 1'b0;
      flag_lo_q <= 1'b0;
    end else begin
      flag_hi_q <= (finish & above) | (flag_hi_q & ~stat_rd);
      flag_lo_q <= (finish & below) | (flag_lo_q & ~stat_rd);
    end
  end

  a_r5_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy_q);
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !conv_done |=> busy_q);
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !conv_start);
  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r6_temp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && conv_done) |=> $stable(temp_q));
  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));
  a_r4_rsvd_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !wr_known |=> $stable(cfg_q) && $stable(rate_q) && $stable(hi_q) && $stable(lo_q));
  a_r10_auto_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    wr && (req_code == ONESHOT) && !standby && (tmr_q < rate_q) |=> !conv_start);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hi_q && !stat_rd |=> flag_hi_q);

endmodule

// File: tb/thermal_cmd_core_tb.sv
module thermal_cmd_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_read = 1'b0;
  logic [7:0] req_code = 8'h00, req_data = 8'h00;
  logic       rsp_valid, conv_start;
  logic [7:0] rsp_data;
  logic       conv_done = 1'b0;
  logic [7:0] conv_result = 8'h00;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thermal_cmd_core u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_code(req_code), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .conv_start(conv_start), .conv_done(conv_done),
    .conv_result(conv_result)
  );

  // {read, code, data, expected}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h0D, 8'h50, 8'h00}, {1'b1, 8'h07, 8'h00, 8'h50},
    {1'b0, 8'h0E, 8'hF0, 8'h00}, {1'b1, 8'h08, 8'h00, 8'hF0},
    {1'b0, 8'h0A, 8'h05, 8'h00}, {1'b1, 8'h04, 8'h00, 8'h05},
    {1'b0, 8'h09, 8'h40, 8'h00}, {1'b1, 8'h03, 8'h00, 8'h40},
    {1'b0, 8'h01, 8'hAA, 8'h00}, {1'b1, 8'h01, 8'h00, 8'h00},
    {1'b0, 8'h05, 8'h33, 8'h00}, {1'b1, 8'h05, 8'h00, 8'h00},
    {1'b1, 8'h09, 8'h00, 8'h00}, {1'b1, 8'hFF, 8'h00, 8'h00},
    {1'b0, 8'h10, 8'h77, 8'h00}, {1'b1, 8'h04, 8'h00, 8'h05}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(input logic rdb, input logic [7:0] code, input logic [7:0] data);
    req_valid = 1'b1; req_read = rdb; req_code = code; req_data = data;
    step();
    req_valid = 1'b0; req_read = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] code, input logic [7:0] exp);
    issue(1'b1, code, 8'h00);
    chk({req, " rsp_valid"}, {7'd0, rsp_valid}, 8'h01);
    chk(req, rsp_data, exp);
  endtask

  task automatic done_pulse(input logic [7:0] res);
    conv_done = 1'b1; conv_result = res;
    step();
    conv_done = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (conv_start) seen++;
    end
    chk(req, seen[7:0], 8'h00);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 conv_start in reset", {7'd0, conv_start}, 8'h00);
    chk("R1 rsp_valid in reset", {7'd0, rsp_valid}, 8'h00);
    rst_n = 1'b1;
    // R11: first automatic start rate(2)+1 edges after release
    for (int i = 1; i <= 4; i++) begin
      step();
      chk($sformatf("R11 start after reset edge %0d", i), {7'd0, conv_start}, (i == 3) ? 8'h01 : 8'h00);
    end
    rd_chk("R1 temp", 8'h01, 8'h00);
    rd_chk("R1 cfg", 8'h03, 8'h00);
    rd_chk("R1 rate", 8'h04, 8'h02);
    rd_chk("R1 high limit", 8'h07, 8'h7F);
    rd_chk("R1 low limit", 8'h08, 8'hC9);
    rd_chk("R5 status busy", 8'h02, 8'h80);

    // R2/R3/R4 vector walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      if (VEC[i][24]) begin
        chk($sformatf("R4/R3 vector %0d valid", i), {7'd0, rsp_valid}, 8'h01);
        chk($sformatf("R4/R3 vector %0d code %h", i, VEC[i][23:16]), rsp_data, VEC[i][7:0]);
      end
    end
    rd_chk("R4 high limit kept", 8'h07, 8'h50);

    // R6/R7: done while busy (auto conversion still running), above high
    done_pulse(8'h60);
    rd_chk("R7 high flag set", 8'h02, 8'h10);
    rd_chk("R7 flags cleared by read", 8'h02, 8'h00);
    rd_chk("R6 temp latched", 8'h01, 8'h60);
    quiet("R8 stand-by no auto start", 12);
    done_pulse(8'h11);
    rd_chk("R6 done while idle ignored", 8'h01, 8'h60);

    // R8/R9: one-shot in stand-by
    issue(1'b0, 8'h0F, 8'h00);
    chk("R8 one-shot start", {7'd0, conv_start}, 8'h01);
    rd_chk("R5 busy after one-shot", 8'h02, 8'h80);
    chk("R8 start is one pulse", {7'd0, conv_start}, 8'h00);
    issue(1'b0, 8'h0F, 8'h00);
    chk("R9 one-shot while busy", {7'd0, conv_start}, 8'h00);
    done_pulse(8'hE0);
    rd_chk("R7 signed low flag", 8'h02, 8'h08);
    quiet("R8 back to stand-by", 12);

    // R7: flag set in same cycle as status read survives
    issue(1'b0, 8'h0F, 8'h00);
    conv_done = 1'b1; conv_result = 8'h80;
    issue(1'b1, 8'h02, 8'h00);
    conv_done = 1'b0;
    chk("R7 read during done sees busy", rsp_data, 8'h80);
    rd_chk("R7 same-cycle set wins", 8'h02, 8'h08);
    rd_chk("R6 temp 80h", 8'h01, 8'h80);

    // R11/R10: auto mode with rate 1
    issue(1'b0, 8'h0A, 8'h01);
    issue(1'b0, 8'h09, 8'h00);
    step();
    chk("R11 not yet after mode change", {7'd0, conv_start}, 8'h00);
    step();
    chk("R11 start rate+1 after mode change", {7'd0, conv_start}, 8'h01);
    done_pulse(8'h20);
    issue(1'b0, 8'h0F, 8'h00);
    chk("R10 one-shot in auto ignored", {7'd0, conv_start}, 8'h00);
    step();
    chk("R11 start rate+1 after done", {7'd0, conv_start}, 8'h01);
    rd_chk("R2 temp 20h no flags path", 8'h01, 8'h20);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule